// File: doc/BRIEF.md
# Two-into-one four-phase handshake merge

This block joins two request/acknowledge channels, on which the surrounding logic is the active party, into one outgoing channel on which the block itself is the active party. All three channels use four-phase (return-to-zero) signalling. When a request arrives on either incoming channel, the block raises the outgoing request. The outgoing acknowledge is passed back only to the incoming channel that started the cycle. The return-to-zero half then travels through the block in the same way.

Inside, everything runs on one clock. When a cycle starts, the block records which incoming channel opened it. That record alone routes the acknowledges until the incoming acknowledge has returned to zero. The two incoming requests must never be high together. The block does not arbitrate between them. If it sees both high, it raises an error flag for that cycle and does not start a transfer.

Top module: `hs_merge2`

## Requirements
- R1: While reset is held and on the first clock after it, cReq, aAck, bAck and protoErr are all low.
- R2: When the block is idle (cReq, aAck, bAck and cAck all low) and exactly one of aReq and bReq is high at a clock edge, cReq is high after that edge.
- R3: Once raised, cReq stays high until the starting channel's request is seen low after its acknowledge has risen. cReq falls on the edge that sees that request low.
- R4: The edge that sees cAck high while cReq is high raises the acknowledge of the starting channel only. The other channel's acknowledge stays low for the whole cycle, and aAck and bAck are never high together.
- R5: After cReq has fallen, the edge that sees cAck low lowers the starting channel's acknowledge. That acknowledge stays high until then.
- R6: A request that rises on the other channel while the current cycle is still returning to zero does not raise cReq until the current acknowledge has fallen. It is then served on the next edge.
- R7: protoErr is high for exactly the clock cycles that follow an edge at which aReq and bReq were both high.
- R8: An edge at which both requests are high while the block is idle does not start a cycle, so cReq stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| aReq | input | 1 | Request on incoming channel a |
| aAck | output | 1 | Acknowledge on incoming channel a |
| bReq | input | 1 | Request on incoming channel b |
| bAck | output | 1 | Acknowledge on incoming channel b |
| cReq | output | 1 | Request on the outgoing channel |
| cAck | input | 1 | Acknowledge on the outgoing channel |
| protoErr | output | 1 | High for one cycle for each edge at which both incoming requests were high |

## Verification
Two functions can meet in the same edge: the end of one cycle's return-to-zero and the start of the next cycle, requested from the other channel. The bench provokes this by raising bReq while aAck is still high and cAck has not yet dropped. It then expects cReq to stay low until aAck has fallen and to rise on the edge after that. A scoreboard queue holds the expected owner of each cycle, and every rising acknowledge is compared against it. The order of a and b cycles is random, and so are the delays before cAck.

// File: rtl/hs_merge_pkg.sv
package hs_merge_pkg;
  localparam int NUM_IN = 2;
  localparam int IDX_A = 0;
  localparam int IDX_B = 1;

  typedef logic [NUM_IN-1:0] inVec_t;

  typedef struct packed {
    logic startCycle;
    logic raiseAck;
    logic dropReq;
    logic dropAck;
  } hsStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_ACK,
    ST_HOLD,
    ST_DRAIN
  } hsState_t;
endpackage

// File: rtl/hs_merge_ctrl.sv
module hs_merge_ctrl
  import hs_merge_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      anySingle,
  input  logic      ownerReq,
  input  logic      cAck,
  output hsStrobe_t strobe
);
  hsState_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (anySingle && !cAck) begin
          strobe.startCycle = 1'b1;
          stateNext         = ST_WAIT_ACK;
        end
      end
      ST_WAIT_ACK: begin
        if (cAck) begin
          strobe.raiseAck = 1'b1;
          stateNext       = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (!ownerReq) begin
          strobe.dropReq = 1'b1;
          stateNext      = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (!cAck) begin
          strobe.dropAck = 1'b1;
          stateNext      = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/hs_merge_dp.sv
module hs_merge_dp
  import hs_merge_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  inVec_t    reqVec,
  input  hsStrobe_t strobe,
  output inVec_t    ackVec,
  output logic      cReq,
  output logic      protoErr,
  output logic      anySingle,
  output logic      ownerReq
);
  inVec_t owner;
  logic   multiReq;

  // more than one bit set: clearing the lowest set bit leaves something
  assign multiReq  = |(reqVec & (reqVec - inVec_t'(1)));
  assign anySingle = (|reqVec) && !multiReq;
  assign ownerReq  = |(reqVec & owner);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 owner <= '0;
    else if (strobe.startCycle) owner <= reqVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  cReq <= 1'b0;
    else if (strobe.startCycle) cReq <= 1'b1;
    else if (strobe.dropReq)    cReq <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) protoErr <= 1'b0;
    else       protoErr <= multiReq;
  end

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_ack
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                              ackVec[gi] <= 1'b0;
      else if (strobe.raiseAck && owner[gi])  ackVec[gi] <= 1'b1;
      else if (strobe.dropAck && owner[gi])   ackVec[gi] <= 1'b0;
    end
  end
endmodule

// File: rtl/hs_merge2.sv
module hs_merge2
  import hs_merge_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic aReq,
  output logic aAck,
  input  logic bReq,
  output logic bAck,
  output logic cReq,
  input  logic cAck,
  output logic protoErr
);
  inVec_t    reqVec;
  inVec_t    ackVec;
  hsStrobe_t strobe;
  logic      anySingle;
  logic      ownerReq;

  assign reqVec[IDX_A] = aReq;
  assign reqVec[IDX_B] = bReq;
  assign aAck = ackVec[IDX_A];
  assign bAck = ackVec[IDX_B];

  hs_merge_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .anySingle (anySingle),
    .ownerReq  (ownerReq),
    .cAck      (cAck),
    .strobe    (strobe)
  );

  hs_merge_dp i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .reqVec    (reqVec),
    .strobe    (strobe),
    .ackVec    (ackVec),
    .cReq      (cReq),
    .protoErr  (protoErr),
    .anySingle (anySingle),
    .ownerReq  (ownerReq)
  );
endmodule

// File: rtl/hs_merge2_chk.sv
module hs_merge2_chk (
  input logic clk,
  input logic rstN,
  input logic aReq,
  input logic aAck,
  input logic bReq,
  input logic bAck,
  input logic cReq,
  input logic cAck,
  input logic protoErr
);
  logic idle;
  assign idle = !cReq && !aAck && !bAck;

  assert_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (idle && !cAck && (aReq ^ bReq)) |=> cReq);

  assert_hold_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cReq && ((aAck && aReq) || (bAck && bReq))) |=> cReq);

  assert_ack_follows_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cReq && cAck && !aAck && !bAck) |=> (aAck ^ bAck));

  assert_one_ack_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(aAck && bAck));

  assert_ack_rtz_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((aAck || bAck) && !cReq && !cAck) |=> (!aAck && !bAck));

  assert_err_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (aReq && bReq) |=> protoErr);

  assert_err_clr_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(aReq && bReq) |=> !protoErr);

  assert_no_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    (idle && aReq && bReq) |=> !cReq);
endmodule

bind hs_merge2 hs_merge2_chk i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .aReq     (aReq),
  .aAck     (aAck),
  .bReq     (bReq),
  .bAck     (bAck),
  .cReq     (cReq),
  .cAck     (cAck),
  .protoErr (protoErr)
);

// File: tb/test_hs_merge2.sv
module test_hs_merge2;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aReq = 1'b0, bReq = 1'b0, cAck = 1'b0;
  logic aAck, bAck, cReq, protoErr;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;
  bit errAllowed = 1'b0;
  int expQ[$];

  always #10 clk = ~clk;

  hs_merge2 i_hs_merge2 (
    .clk(clk), .rstN(rstN), .aReq(aReq), .aAck(aAck), .bReq(bReq),
    .bAck(bAck), .cReq(cReq), .cAck(cAck), .protoErr(protoErr)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic ackOf(input int sel);
    return (sel == 0) ? aAck : bAck;
  endfunction

  task automatic setReq(input int sel, input logic v);
    if (sel == 0) aReq = v; else bReq = v;
  endtask

  // scoreboard monitor: each rising acknowledge must match the queued owner
  logic prevA = 1'b0, prevB = 1'b0;
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (aAck && !prevA) begin
        if (expQ.size() == 0) check("R4 unexpected aAck", 0, 1);
        else check("R4 aAck owner", 0, expQ.pop_front());
      end
      if (bAck && !prevB) begin
        if (expQ.size() == 0) check("R4 unexpected bAck", 1, 0);
        else check("R4 bAck owner", 1, expQ.pop_front());
      end
      if (protoErr && !errAllowed) check("R7 spurious protoErr", 1, 0);
    end
    prevA = aAck;
    prevB = bAck;
  end

  task automatic runCycle(input int sel, input int dly, input int hold);
    @(negedge clk);
    setReq(sel, 1'b1);
    expQ.push_back(sel);
    @(negedge clk);
    check("R2 cReq rises", cReq, 1);
    repeat (dly) @(negedge clk);
    check("R4 no early ack", ackOf(sel), 0);
    cAck = 1'b1;
    @(negedge clk);
    check("R4 owner ack", ackOf(sel), 1);
    check("R4 other ack low", ackOf(1 - sel), 0);
    repeat (hold) begin
      @(negedge clk);
      check("R3 cReq held", cReq, 1);
    end
    setReq(sel, 1'b0);
    @(negedge clk);
    check("R3 cReq falls", cReq, 0);
    check("R5 ack held", ackOf(sel), 1);
    cAck = 1'b0;
    @(negedge clk);
    check("R5 ack falls", ackOf(sel), 0);
    check("R4 other ack low at end", ackOf(1 - sel), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (2) @(negedge clk);
    check("R1 cReq in reset", cReq, 0);
    check("R1 aAck in reset", aAck, 0);
    check("R1 bAck in reset", bAck, 0);
    check("R1 protoErr in reset", protoErr, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 cReq after reset", cReq, 0);
    check("R1 protoErr after reset", protoErr, 0);

    runCycle(0, 0, 0);
    runCycle(1, 3, 2);
    for (int i = 0; i < 20; i++) begin
      runCycle(int'($urandom_range(1, 0)), int'($urandom_range(4, 0)),
               int'($urandom_range(3, 0)));
    end

    // R6: b requests while a is still returning to zero
    @(negedge clk);
    aReq = 1'b1; expQ.push_back(0);
    @(negedge clk);
    cAck = 1'b1;
    @(negedge clk);
    check("R6 aAck up", aAck, 1);
    aReq = 1'b0;
    @(negedge clk);
    check("R6 cReq down", cReq, 0);
    bReq = 1'b1; expQ.push_back(1);
    repeat (2) begin
      @(negedge clk);
      check("R6 cReq held off", cReq, 0);
      check("R6 bAck low", bAck, 0);
    end
    cAck = 1'b0;
    @(negedge clk);
    check("R6 aAck down", aAck, 0);
    check("R6 cReq not yet", cReq, 0);
    @(negedge clk);
    check("R6 b served", cReq, 1);
    cAck = 1'b1;
    @(negedge clk);
    check("R6 bAck up", bAck, 1);
    check("R6 aAck stays low", aAck, 0);
    bReq = 1'b0;
    @(negedge clk);
    cAck = 1'b0;
    @(negedge clk);
    check("R6 bAck down", bAck, 0);

    // R7 and R8: both requests high while idle
    errAllowed = 1'b1;
    @(negedge clk);
    aReq = 1'b1; bReq = 1'b1;
    @(negedge clk);
    check("R7 protoErr set", protoErr, 1);
    check("R8 no start", cReq, 0);
    @(negedge clk);
    check("R7 protoErr still set", protoErr, 1);
    check("R8 still idle", cReq, 0);
    aReq = 1'b0; bReq = 1'b0;
    @(negedge clk);
    check("R7 protoErr clear", protoErr, 0);
    check("R8 acks low", aAck | bAck, 0);
    errAllowed = 1'b0;

    runCycle(1, 1, 1);
    check("R4 scoreboard drained", expQ.size(), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule